// File: doc/BRIEF.md
# Timer-Paced SPI Waveform DAC Streamer

This block plays a stored waveform out to an external dual-channel 12-bit DAC over a serial master link. A free-running sample timer counts from zero up to a programmable period value and then wraps. Each wrap launches one 16-bit write command. The command carries the next entry of a small on-chip waveform table, which is read in order and starts again from the first entry after the last one. The serial clock is the system clock divided by a programmable amount. The data line changes on the falling clock edge, so the DAC can capture it on the rising edge.

The active-low select is not tied to the shifter. It comes from a two-compare pulse unit that watches the same sample timer. The select opens a fixed lead of counts before the wrap and closes when the counter reaches a separately programmed close value. This frames each transfer with no software timing at all. Software loads the table through a write port. It sets the period, the close value, the clock divisor and the three command flags (channel, gain, enable) as static inputs.

Top module: `wavedac_streamer`

## Requirements
- R1: Each transfer is a 16-bit word sent MSB first. Bit 15 is the channel (1 = B, 0 = A), bit 14 is always 0, bit 13 is the gain flag (1 = unity gain, 0 = double gain), bit 12 is the active-low shutdown (1 = output enabled), and bits 11..0 are the table sample.
- R2: The sample timer counts 0, 1, ... up to `period` and then returns to 0. A transfer starts on the clock edge where the count equals `period`, so consecutive transfers begin `period`+1 clocks apart.
- R3: Samples are taken from the table in ascending index order, starting at entry 0 and wrapping to entry 0 after entry DEPTH-1. A value written through `tbl_we`/`tbl_addr`/`tbl_data` is the value later sent for that entry.
- R4: `cs_n` goes low one clock after the counter holds `period` minus LEAD (LEAD = 4). It therefore falls LEAD+`half_div` clocks before the first rising SCK edge of the transfer.
- R5: `cs_n` returns high one clock after the counter holds `sel_len`, so the low window lasts `sel_len`+LEAD+1 clocks. `cs_n` is low at every rising SCK edge of a transfer when `sel_len` is chosen to cover the shift.
- R6: SCK idles low. While shifting, it is high for `half_div` clocks and low for `half_div` clocks per bit, giving a rate of clk/(2·`half_div`). A value of 0 acts as 1.
- R7: SDO changes only when SCK falls or when a word is loaded, never at a rising SCK edge. SDO is 0 while no transfer is in progress.
- R8: A period match that arrives while a shift is still running starts nothing. It leaves the table pointer unchanged and sets `overrun`, which stays set until reset. The skipped sample is sent at the next accepted match.
- R9: After reset, `cs_n` is high, `sck`, `sdo` and `overrun` are low, the counter is 0, and the first transfer sends table entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_we | input | 1 | Waveform table write strobe |
| tbl_addr | input | AW = clog2(DEPTH) | Table entry to write |
| tbl_data | input | 12 | Sample value to write |
| period | input | CNT_W | Terminal count of the sample timer |
| sel_len | input | CNT_W | Counter value that closes the select window |
| half_div | input | DIV_W | System clocks per SCK half-cycle |
| chan_b | input | 1 | Channel flag placed in bit 15 |
| gain_x1 | input | 1 | Gain flag placed in bit 13 |
| dac_on | input | 1 | Enable flag placed in bit 12 (active-low shutdown) |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low select from the compare unit |
| overrun | output | 1 | Sticky flag: a period match hit a busy shifter |

## Verification
The main function is tried with three stimulus sets. The first uses a unity divisor, a period that leaves room to spare and flags set to channel A, unity gain and enabled. It runs past the end of the table, which separates a correct wrap from a pointer that overruns or sticks, and it confirms exact window and spacing counts. The second uses a divisor of three, a longer period, the opposite value of every command flag and a rewritten table entry. It shows that each flag bit is in its own position, that the divisor scales both SCK phases, and that a reset in mid-stream brings the pointer back to entry 0. The third uses a period shorter than one shift. It shows that overlapping matches are dropped without losing samples, that spacing becomes two periods, and that the overrun flag latches.

// File: rtl/wds_pkg.sv
package wds_pkg;

   localparam int CMD_W  = 16;
   localparam int SMP_W  = 12;

   typedef logic [CMD_W-1:0] cmd_word_t;
   typedef logic [SMP_W-1:0] sample_t;

   // Pack the DAC write command: channel, fixed zero, gain, enable, sample
   function automatic cmd_word_t pack_cmd(input logic    chan_b,
                                          input logic    gain_x1,
                                          input logic    enable,
                                          input sample_t smp);
      return {chan_b, 1'b0, gain_x1, enable, smp};
   endfunction

endpackage

// File: rtl/wds_timer.sv
module wds_timer #(
   parameter int CNT_W = 16,
   parameter int LEAD  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] sel_len,
   output logic             match,
   output logic             cs_n
);

   localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic             open_hit;
   logic             close_hit;

   // a count past a shrunken period also wraps
   assign match     = (cnt >= period);
   assign open_hit  = (period >= LEAD_C) && (cnt == period - LEAD_C);
   assign close_hit = (cnt == sel_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (match) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + ONE_C;
      end
   end

   // dual compare pulse: opening compare wins a tie
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n <= 1'b1;
      end else if (open_hit) begin
         cs_n <= 1'b0;
      end else if (close_hit) begin
         cs_n <= 1'b1;
      end
   end

endmodule

// File: rtl/wds_table.sv
module wds_table #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 12,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              adv,
   output logic [DATA_W-1:0] rdata
);

   localparam bit            POW2   = (DEPTH == (1 << AW));
   localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);
   localparam logic [AW-1:0] ONE_C  = AW'(1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     ptr;
   logic [AW-1:0]     ptr_nxt;

   always_ff @(posedge clk) begin
      if (we && (POW2 || waddr <= LAST_C)) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[ptr];

   generate
      if (POW2) begin : g_wrap_natural
         assign ptr_nxt = ptr + ONE_C;
      end else begin : g_wrap_compare
         assign ptr_nxt = (ptr == LAST_C) ? '0 : ptr + ONE_C;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= ptr_nxt;
      end
   end

endmodule

// File: rtl/wds_shifter.sv
module wds_shifter #(
   parameter int CMD_W = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CMD_W-1:0] word,
   input  logic [DIV_W-1:0] half_div,
   output logic             busy,
   output logic             sck,
   output logic             sdo
);

   localparam int               BW     = $clog2(CMD_W);
   localparam logic [BW-1:0]    LAST_B = BW'(CMD_W - 1);
   localparam logic [BW-1:0]    ONE_B  = BW'(1);
   localparam logic [DIV_W-1:0] ONE_D  = DIV_W'(1);

   logic [DIV_W-1:0] half_eff;
   logic [DIV_W-1:0] hc;
   logic [BW-1:0]    nb;
   logic [CMD_W-1:0] sh;

   assign half_eff = (half_div == '0) ? ONE_D : half_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         sh   <= '0;
         hc   <= '0;
         nb   <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            sck  <= 1'b0;
            sh   <= word;
            hc   <= '0;
            nb   <= '0;
         end
      end else if (hc == half_eff - ONE_D) begin
         hc  <= '0;
         sck <= ~sck;
         if (sck) begin
            // falling edge: present the next bit
            sh <= {sh[CMD_W-2:0], 1'b0};
            if (nb == LAST_B) begin
               busy <= 1'b0;
            end else begin
               nb <= nb + ONE_B;
            end
         end
      end else begin
         hc <= hc + ONE_D;
      end
   end

   assign sdo = busy & sh[CMD_W-1];

endmodule

// File: rtl/wavedac_streamer.sv
module wavedac_streamer #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 16,
   parameter int DIV_W = 8,
   parameter int LEAD  = 4,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tbl_we,
   input  logic [AW-1:0]             tbl_addr,
   input  logic [wds_pkg::SMP_W-1:0] tbl_data,
   input  logic [CNT_W-1:0]          period,
   input  logic [CNT_W-1:0]          sel_len,
   input  logic [DIV_W-1:0]          half_div,
   input  logic                      chan_b,
   input  logic                      gain_x1,
   input  logic                      dac_on,
   output logic                      sck,
   output logic                      sdo,
   output logic                      cs_n,
   output logic                      overrun
);

   import wds_pkg::*;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wavedac_streamer: DEPTH must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("wavedac_streamer: DIV_W must be at least 1");
      end
      if (LEAD < 1 || CNT_W <= $clog2(LEAD + 1)) begin : g_bad_lead
         $error("wavedac_streamer: LEAD must be positive and fit in CNT_W");
      end
   endgenerate

   logic      tmr_match;
   logic      sh_busy;
   logic      take;
   sample_t   smp;
   cmd_word_t word;

   // a match only advances the table when the shifter can take it
   assign take = tmr_match & ~sh_busy;
   assign word = pack_cmd(chan_b, gain_x1, dac_on, smp);

   wds_timer #(.CNT_W(CNT_W), .LEAD(LEAD)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .period  (period),
      .sel_len (sel_len),
      .match   (tmr_match),
      .cs_n    (cs_n)
   );

   wds_table #(.DEPTH(DEPTH), .DATA_W(SMP_W), .AW(AW)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tbl_we),
      .waddr (tbl_addr),
      .wdata (tbl_data),
      .adv   (take),
      .rdata (smp)
   );

   wds_shifter #(.CMD_W(CMD_W), .DIV_W(DIV_W)) u_shf (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (take),
      .word     (word),
      .half_div (half_div),
      .busy     (sh_busy),
      .sck      (sck),
      .sdo      (sdo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overrun <= 1'b0;
      end else if (tmr_match && sh_busy) begin
         overrun <= 1'b1;
      end
   end

endmodule

// File: rtl/wds_checker.sv
module wds_top_chk (
   input logic clk,
   input logic rst_n,
   input logic tmr_match,
   input logic sh_busy,
   input logic sck,
   input logic sdo,
   input logic overrun
);
   p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_match && sh_busy) |=> overrun);
   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> !sck);
   p_sdo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_busy |-> !sdo);
   p_sdo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(sdo));
endmodule

module wds_timer_chk #(
   parameter int CNT_W = 16,
   parameter int LEAD  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] sel_len,
   input logic             match,
   input logic             cs_n
);
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (cnt == '0));
   p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !match |=> (cnt == $past(cnt) + CNT_W'(1)));
   p_cs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (period >= CNT_W'(LEAD) && cnt == period - CNT_W'(LEAD)) |=> !cs_n);
   p_cs_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == sel_len && !(period >= CNT_W'(LEAD) && cnt == period - CNT_W'(LEAD)))
      |=> cs_n);
endmodule

module wds_table_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adv,
   input logic [AW-1:0] ptr
);
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (ptr != $past(ptr)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> (ptr == $past(ptr)));
endmodule

bind wavedac_streamer wds_top_chk u_top_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tmr_match (tmr_match),
   .sh_busy   (sh_busy),
   .sck       (sck),
   .sdo       (sdo),
   .overrun   (overrun)
);

bind wds_timer wds_timer_chk #(.CNT_W(CNT_W), .LEAD(LEAD)) u_tmr_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt     (cnt),
   .period  (period),
   .sel_len (sel_len),
   .match   (match),
   .cs_n    (cs_n)
);

bind wds_table wds_table_chk #(.AW(AW)) u_tbl_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .adv   (adv),
   .ptr   (ptr)
);

// File: tb/wavedac_streamer_tb_top.sv
module wavedac_streamer_tb_top;

   localparam int DEPTH = 16;
   localparam int CNT_W = 16;
   localparam int DIV_W = 8;
   localparam int LEAD  = 4;
   localparam int AW    = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tbl_we = 1'b0;
   logic [AW-1:0]    tbl_addr = '0;
   logic [11:0]      tbl_data = '0;
   logic [CNT_W-1:0] period = '0;
   logic [CNT_W-1:0] sel_len = '0;
   logic [DIV_W-1:0] half_div = '0;
   logic             chan_b = 1'b0;
   logic             gain_x1 = 1'b0;
   logic             dac_on = 1'b0;
   logic             sck, sdo, cs_n, overrun;

   always #5 clk = ~clk;

   wavedac_streamer #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W), .LEAD(LEAD)) dut_i (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_data(tbl_data), .period(period), .sel_len(sel_len),
      .half_div(half_div), .chan_b(chan_b), .gain_x1(gain_x1),
      .dac_on(dac_on), .sck(sck), .sdo(sdo), .cs_n(cs_n), .overrun(overrun)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] expq[$];
   logic [11:0] tbl [DEPTH];

   int exp_gap, exp_lead, exp_win, exp_half;
   bit chk_cs = 1'b0;
   bit mon_on = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ---------------- monitor: rebuild words from the serial pins ----------
   int          cyc = 0;
   logic        pcs = 1'b1, psck = 1'b0;
   int          cs_fall = 0, rise_cyc = 0, first_prev = 0, nbits = 0;
   bit          have_prev = 1'b0;
   logic [15:0] acc = '0;

   always @(negedge clk) begin
      cyc++;
      if (!mon_on) begin
         pcs = 1'b1; psck = 1'b0; nbits = 0; have_prev = 1'b0;
      end else begin
         if (pcs && !cs_n) cs_fall = cyc;
         if (!pcs && cs_n && chk_cs) check("R5 window", cyc - cs_fall, exp_win);
         if (chk_cs && cs_n) begin
            check("R7 idle sdo", int'(sdo), 0);
            check("R6 idle sck", int'(sck), 0);
         end
         if (!psck && sck) begin
            rise_cyc = cyc;
            if (nbits == 0) begin
               if (chk_cs) check("R4 lead", cyc - cs_fall, exp_lead);
               if (have_prev) check("R2 spacing", cyc - first_prev, exp_gap);
               first_prev = cyc;
               have_prev  = 1'b1;
            end
            if (chk_cs) check("R5 cs low at rise", int'(cs_n), 0);
            acc   = {acc[14:0], sdo};
            nbits = nbits + 1;
            if (nbits == 16) begin
               nbits = 0;
               if (expq.size() == 0) begin
                  check("R1 R3 unexpected word", int'(acc), -1);
               end else begin
                  check("R1 R3 word", int'(acc), int'(expq.pop_front()));
               end
            end
         end
         if (psck && !sck) check("R6 high time", cyc - rise_cyc, exp_half);
         pcs  = cs_n;
         psck = sck;
      end
   end

   // ---------------- driver ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic write_entry(input int idx, input logic [11:0] val);
      tbl_we = 1'b1; tbl_addr = AW'(idx); tbl_data = val;
      tbl[idx] = val;
      tick();
      tbl_we = 1'b0;
   endtask

   task automatic push_words(input int first, input int count, input int step);
      for (int k = 0; k < count; k++) begin
         expq.push_back({chan_b, 1'b0, gain_x1, dac_on, tbl[(first + k * step) % DEPTH]});
      end
   endtask

   task automatic drain(input int lim);
      int g = 0;
      while (expq.size() != 0 && g < lim) begin
         @(posedge clk);
         g++;
      end
      check("R2 R3 all words sent", expq.size(), 0);
   endtask

   task automatic enter_reset();
      tick();
      mon_on = 1'b0;
      rst_n  = 1'b0;
      tick();
   endtask

   task automatic leave_reset();
      rst_n  = 1'b1;
      mon_on = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      // phase A: unity divisor, channel A, unity gain, enabled
      rst_n = 1'b0;
      period = 16'd99; sel_len = 16'd70; half_div = 8'd1;
      chan_b = 1'b0; gain_x1 = 1'b1; dac_on = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         write_entry(i, (i == 0) ? 12'hFFF : (i == 1) ? 12'h000 : 12'((i * 309 + 7) & 12'hFFF));
      end
      repeat (3) tick();
      // R9: reset state at the ports
      check("R9 cs_n", int'(cs_n), 1);
      check("R9 sck", int'(sck), 0);
      check("R9 sdo", int'(sdo), 0);
      check("R9 overrun", int'(overrun), 0);
      exp_gap = 100; exp_lead = LEAD + 1; exp_win = 70 + LEAD + 1; exp_half = 1;
      chk_cs = 1'b1;
      push_words(0, 20, 1);               // R3 wrap past entry 15
      leave_reset();
      drain(4000);
      check("R8 no overrun", int'(overrun), 0);

      // phase B: divisor 3, flags inverted, rewritten entry, mid-stream reset
      enter_reset();
      write_entry(5, 12'h5A5);
      period = 16'd199; sel_len = 16'd140; half_div = 8'd3;
      chan_b = 1'b1; gain_x1 = 1'b0; dac_on = 1'b0;
      exp_gap = 200; exp_lead = LEAD + 3; exp_win = 140 + LEAD + 1; exp_half = 3;
      push_words(0, 18, 1);               // R9 restart from entry 0
      leave_reset();
      drain(6000);
      check("R8 no overrun", int'(overrun), 0);

      // phase C: period shorter than a shift
      enter_reset();
      period = 16'd20; sel_len = 16'd10; half_div = 8'd1;
      chan_b = 1'b0; gain_x1 = 1'b1; dac_on = 1'b1;
      chk_cs = 1'b0;
      exp_gap = 42; exp_half = 1;         // R8 every second match accepted
      push_words(0, 5, 1);                // R8 no sample lost
      leave_reset();
      drain(1000);
      check("R8 overrun set", int'(overrun), 1);
      repeat (30) tick();
      check("R8 overrun sticky", int'(overrun), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule